// File: doc/BRIEF.md
# Saturating Fixed-Point ALU for 40-bit Register Words

This unit performs one 32-bit two's-complement fixed-point operation per clock. It sits next to a register file whose data words are 40 bits wide. Each operand is the top 32 bits of its 40-bit source word. The result goes back into the top 32 bits of a 40-bit destination word, and the bottom byte of that word is written as zero. The operation is decoded from a 4-bit code. The set covers add, subtract, add-with-carry, subtract-with-borrow, negate, absolute value, pass, compare, and the bitwise AND, OR, XOR and NOT.

The write-back word and its write enable are combinational, so they appear in the same cycle as the operation. This lets a destination register also be one of the sources. The four status flags (zero, negative, overflow, carry) live in a small register. That register loads on the clock edge that ends a valid operation. Add-with-carry and subtract-with-borrow read the carry flag held there. A saturation-mode input chooses how signed overflow is handled. When it is set, overflowing results clamp to the largest positive or most negative value. When it is clear, they wrap. The overflow flag always reports the unclamped result. Compare sets the flags and writes nothing.

Top module: `fxalu_top`

## Requirements
- R1: The operands are `src_a[39:8]` and `src_b[39:8]`. Bits [7:0] of either source have no effect on the write-back word or on the flags.
- R2: For a writing operation with `op_valid` high, `wr_en` is high in that same cycle. `wr_data[39:8]` carries the result and `wr_data[7:0]` is zero.
- R3: Opcodes: 0 add (a+b), 1 subtract (a-b), 4 negate (-a), 5 absolute value, 6 pass (a). Carry is the carry out of bit 31 of the add. For subtract it means "no borrow" (a >= b unsigned). For negate it is set only when a is zero. Absolute value and pass clear carry.
- R4: The overflow flag is set when the exact signed result lies outside the 32-bit signed range. This holds whatever the value of `sat_en`.
- R5: With `sat_en`=1, a positive overflow writes 0x7FFFFFFF and a negative overflow writes 0x80000000.
- R6: With `sat_en`=0, an overflowing result is the low 32 bits of the exact result (wrapped).
- R7: Negate and absolute value of 0x80000000 set overflow. They give 0x7FFFFFFF when saturating and 0x80000000 when not.
- R8: Opcode 7 (compare) computes a-b for the flags only. `wr_en` stays low.
- R9: Opcodes 8 AND, 9 OR, 10 XOR and 11 NOT (~a) give the bitwise result, never saturate, and clear both overflow and carry.
- R10: The zero and negative flags describe the final result, after saturation.
- R11: The flags change only at a clock edge where `op_valid` is high with opcode 0 to 11, and become visible after that edge. Codes 12 to 15 write nothing and leave the flags as they are. Reset clears all flags.
- R12: Opcode 2 (add with carry) computes a+b+C. Opcode 3 (subtract with borrow) computes a-b-1+C, where C is the held carry flag. Their carry out follows the same rules as add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| sat_en | input | 1 | 1: clamp on overflow, 0: wrap |
| src_a | input | 40 | First source register word |
| src_b | input | 40 | Second source register word |
| wr_en | output | 1 | Destination write strobe |
| wr_data | output | 40 | Destination word, low byte zero |
| flag_zero | output | 1 | Final result is zero |
| flag_neg | output | 1 | Final result bit 31 |
| flag_ovf | output | 1 | Signed overflow before clamping |
| flag_carry | output | 1 | Carry / no-borrow |

## Verification
The write-back word and its strobe are due in the cycle the operation is presented. The bench drives at a falling edge and compares them one nanosecond later, before the next rising edge. The flags are due one rising edge later. They are compared at the following falling edge, against a model that is updated only for valid, defined opcodes. That same comparison at an idle or reserved cycle checks that the flags hold their value.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADC = 4'd2,  OP_SBB = 4'd3,
        OP_NEG  = 4'd4,  OP_ABS  = 4'd5,  OP_PASS = 4'd6, OP_CMP = 4'd7,
        OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR = 4'd10, OP_NOT = 4'd11,
        OP_R12  = 4'd12, OP_R13  = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
    } op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic carry;
    } flags_t;
endpackage

// File: rtl/fxalu_unpack.sv
module fxalu_unpack #(
    parameter int REG_W = 40,
    parameter int LOW_W = 8,
    localparam int OPD_W = REG_W - LOW_W
) (
    input  logic [REG_W-1:0] word_a,
    input  logic [REG_W-1:0] word_b,
    output logic [OPD_W-1:0] opd_a,
    output logic [OPD_W-1:0] opd_b
);
    logic [1:0][REG_W-1:0] words;
    logic [1:0][OPD_W-1:0] opds;
    logic [1:0][LOW_W-1:0] unused_low;

    assign words = {word_b, word_a};

    // R1: only the upper field of each word is an operand
    for (genvar i = 0; i < 2; i++) begin : g_port
        assign opds[i]       = words[i][REG_W-1:LOW_W];
        assign unused_low[i] = words[i][LOW_W-1:0];
    end

    assign opd_a = opds[0];
    assign opd_b = opds[1];
endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
    import fxalu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] raw,
    output logic         ovf,
    output logic         cout,
    output logic         writes,
    output logic         updates
);
    logic [W-1:0] x, y;
    logic         ci;
    logic [W:0]   sum;
    logic         use_add, keep_carry;

    assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};

    always_comb begin
        x          = a;
        y          = '0;
        ci         = 1'b0;
        use_add    = 1'b1;
        keep_carry = 1'b1;
        writes     = 1'b1;
        updates    = 1'b1;
        raw        = '0;
        unique case (op)
            OP_ADD:  y = b;
            OP_SUB:  begin y = ~b; ci = 1'b1; end
            OP_ADC:  begin y = b;  ci = cin;  end
            OP_SBB:  begin y = ~b; ci = cin;  end
            OP_NEG:  begin x = '0; y = ~a; ci = 1'b1; end
            OP_ABS:  begin
                keep_carry = 1'b0;
                if (a[W-1]) begin x = '0; y = ~a; ci = 1'b1; end
            end
            OP_PASS: keep_carry = 1'b0;
            OP_CMP:  begin y = ~b; ci = 1'b1; writes = 1'b0; end
            OP_AND:  begin use_add = 1'b0; raw = a & b; end
            OP_OR:   begin use_add = 1'b0; raw = a | b; end
            OP_XOR:  begin use_add = 1'b0; raw = a ^ b; end
            OP_NOT:  begin use_add = 1'b0; raw = ~a;    end
            default: begin use_add = 1'b0; writes = 1'b0; updates = 1'b0; end
        endcase
        if (use_add) begin
            raw  = sum[W-1:0];
            ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
            cout = keep_carry & sum[W];
        end else begin
            ovf  = 1'b0;
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/fxalu_sat.sv
module fxalu_sat #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw,
    input  logic         ovf,
    input  logic         sat_en,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    // wrapped sign is opposite to the true sign on overflow
    always_comb begin
        if (sat_en && ovf) res = raw[W-1] ? POS_MAX : NEG_MAX;
        else               res = raw;
    end
endmodule

// File: rtl/fxalu_top.sv
module fxalu_top
    import fxalu_pkg::*;
#(
    parameter int REG_W = 40,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             sat_en,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             flag_zero,
    output logic             flag_neg,
    output logic             flag_ovf,
    output logic             flag_carry
);
    localparam int OPD_W = REG_W - LOW_W;

    op_e              op;
    logic [OPD_W-1:0] opd_a, opd_b, raw, res;
    logic             core_ovf, core_cout, core_wr, core_upd;
    flags_t           flags_q, flags_d;

    assign op = op_e'(op_code);

    fxalu_unpack #(.REG_W(REG_W), .LOW_W(LOW_W)) u_unpack (
        .word_a(src_a), .word_b(src_b), .opd_a(opd_a), .opd_b(opd_b)
    );

    fxalu_core #(.W(OPD_W)) u_core (
        .op(op), .a(opd_a), .b(opd_b), .cin(flags_q.carry),
        .raw(raw), .ovf(core_ovf), .cout(core_cout),
        .writes(core_wr), .updates(core_upd)
    );

    fxalu_sat #(.W(OPD_W)) u_sat (
        .raw(raw), .ovf(core_ovf), .sat_en(sat_en), .res(res)
    );

    assign wr_en   = op_valid & core_wr;
    assign wr_data = {res, {LOW_W{1'b0}}};

    always_comb begin
        flags_d.zero  = (res == '0);
        flags_d.neg   = res[OPD_W-1];
        flags_d.ovf   = core_ovf;
        flags_d.carry = core_cout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     flags_q <= '0;
        else if (op_valid && core_upd)  flags_q <= flags_d;
    end

    assign flag_zero  = flags_q.zero;
    assign flag_neg   = flags_q.neg;
    assign flag_ovf   = flags_q.ovf;
    assign flag_carry = flags_q.carry;

    assert_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[LOW_W-1:0] == '0);

    assert_cmp_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CMP) |-> !wr_en);

    assert_sat_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sat_en && core_ovf) |->
        (wr_data[REG_W-1:LOW_W] == {1'b0, {(OPD_W-1){1'b1}}} ||
         wr_data[REG_W-1:LOW_W] == {1'b1, {(OPD_W-1){1'b0}}}));

    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_zero, flag_neg, flag_ovf, flag_carry}));

    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOT))
        |=> (!flag_ovf && !flag_carry));

    assert_ovf_unsat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && core_upd) |=> flag_ovf == $past(core_ovf));
endmodule

// File: tb/test_fxalu_top.sv
module test_fxalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        sat_en = 1'b0;
    logic [39:0] src_a = '0, src_b = '0;
    logic        wr_en;
    logic [39:0] wr_data;
    logic        flag_zero, flag_neg, flag_ovf, flag_carry;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_flags = 4'b0;
    string      prev_tag = "R11";

    always #2 clk = ~clk;

    fxalu_top i_fxalu_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sat_en(sat_en), .src_a(src_a), .src_b(src_b), .wr_en(wr_en),
        .wr_data(wr_data), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_ovf(flag_ovf), .flag_carry(flag_carry)
    );

    task automatic check(input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: exact arithmetic in 64-bit integers
    task automatic model(input logic [3:0] op, input bit sat,
                         input logic [39:0] wa, input logic [39:0] wb, input bit cin,
                         output bit we, output logic [31:0] r, output bit upd,
                         output logic [3:0] fl);
        longint sa, sb, ua, ub, ex;
        bit arith, o, c;
        sa = longint'($signed(wa[39:8]));
        sb = longint'($signed(wb[39:8]));
        ua = {32'd0, wa[39:8]};
        ub = {32'd0, wb[39:8]};
        arith = 1; o = 0; c = 0; ex = 0; r = '0;
        we = (op <= 4'd11) && (op != 4'd7);
        upd = (op <= 4'd11);
        case (op)
            4'd0: begin ex = sa + sb; c = ((ua + ub) >> 32) != 0; end
            4'd1, 4'd7: begin ex = sa - sb; c = (ua >= ub); end
            4'd2: begin ex = sa + sb + cin; c = ((ua + ub + cin) >> 32) != 0; end
            4'd3: begin ex = sa - sb - 1 + cin; c = (ua + cin) > ub; end
            4'd4: begin ex = -sa; c = (ua == 0); end
            4'd5: ex = (sa < 0) ? -sa : sa;
            4'd6: ex = sa;
            4'd8: begin arith = 0; r = wa[39:8] & wb[39:8]; end
            4'd9: begin arith = 0; r = wa[39:8] | wb[39:8]; end
            4'd10: begin arith = 0; r = wa[39:8] ^ wb[39:8]; end
            4'd11: begin arith = 0; r = ~wa[39:8]; end
            default: arith = 0;
        endcase
        if (arith) begin
            o = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
            r = ex[31:0];
            if (sat && o) r = (ex > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        end
        fl = {r == 32'd0, r[31], o, c};
    endtask

    task automatic step(input bit v, input logic [3:0] op, input bit sat,
                        input logic [39:0] a, input logic [39:0] b, input string tag);
        bit we, upd;
        logic [31:0] r;
        logic [3:0] fl;
        @(negedge clk);
        check(prev_tag, "flags", {36'd0, flag_zero, flag_neg, flag_ovf, flag_carry},
              {36'd0, exp_flags});
        op_valid = v; op_code = op; sat_en = sat; src_a = a; src_b = b;
        model(op, sat, a, b, exp_flags[0], we, r, upd, fl);
        #1;
        check(tag, "wr_en", {39'd0, wr_en}, {39'd0, v & we});
        if (v && we) check(tag, "wr_data", wr_data, {r, 8'h00});
        if (v && upd) exp_flags = fl;
        prev_tag = tag;
    endtask

    function automatic logic [39:0] rnd_word();
        logic [31:0] w;
        case ($urandom % 6)
            0: w = 32'h7FFF_FFFF;
            1: w = 32'h8000_0000;
            2: w = 32'h0;
            3: w = 32'hFFFF_FFFF;
            default: w = $urandom;
        endcase
        return {w, 8'($urandom)};
    endfunction

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state compared by the first step
        step(0, 4'd0, 0, '0, '0, "R11");
        // R1: junk in low bytes
        step(1, 4'd0, 0, {32'd5, 8'hFF}, {32'd3, 8'hAA}, "R1");
        step(1, 4'd6, 0, {32'hFFFF_FFFF, 8'h5A}, '0, "R2");
        // R5 / R4 / R6
        step(1, 4'd0, 1, {32'h7FFF_FFFF, 8'h0}, {32'd1, 8'h0}, "R5");
        step(1, 4'd0, 1, {32'h8000_0000, 8'h0}, {32'hFFFF_FFFF, 8'h0}, "R5");
        step(1, 4'd0, 0, {32'h7FFF_FFFF, 8'h0}, {32'd1, 8'h0}, "R6");
        step(1, 4'd1, 0, {32'h8000_0000, 8'h0}, {32'd1, 8'h0}, "R4");
        // R10: zero flag from final result
        step(1, 4'd0, 0, {32'h8000_0000, 8'h0}, {32'h8000_0000, 8'h0}, "R10");
        step(1, 4'd0, 1, {32'h8000_0000, 8'h0}, {32'h8000_0000, 8'h0}, "R10");
        // R7
        step(1, 4'd4, 1, {32'h8000_0000, 8'h0}, '0, "R7");
        step(1, 4'd5, 1, {32'h8000_0000, 8'h0}, '0, "R7");
        step(1, 4'd4, 0, {32'h8000_0000, 8'h0}, '0, "R7");
        step(1, 4'd4, 0, '0, '0, "R3");
        step(1, 4'd5, 0, {32'hFFFF_FFF6, 8'h0}, '0, "R3");
        // R8
        step(1, 4'd7, 0, {32'd5, 8'h0}, {32'd5, 8'h0}, "R8");
        step(1, 4'd7, 1, {32'h8000_0000, 8'h0}, {32'd1, 8'h0}, "R8");
        // R9 after an overflowing op
        step(1, 4'd0, 0, {32'h8000_0000, 8'h0}, {32'h8000_0000, 8'h0}, "R9");
        step(1, 4'd8, 1, {32'hF0F0_F0F0, 8'h0}, {32'hFF00_FF00, 8'h0}, "R9");
        step(1, 4'd9, 1, {32'hF0F0_F0F0, 8'h0}, {32'h0F0F_0F0F, 8'h0}, "R9");
        step(1, 4'd10, 1, {32'hAAAA_AAAA, 8'h0}, {32'hFFFF_FFFF, 8'h0}, "R9");
        step(1, 4'd11, 1, {32'h1234_5678, 8'h0}, '0, "R9");
        // R12: carry chain
        step(1, 4'd0, 0, {32'hFFFF_FFFF, 8'h0}, {32'd1, 8'h0}, "R12");
        step(1, 4'd2, 0, {32'd10, 8'h0}, {32'd20, 8'h0}, "R12");
        step(1, 4'd3, 0, {32'd10, 8'h0}, {32'd3, 8'h0}, "R12");
        step(1, 4'd1, 0, {32'd1, 8'h0}, {32'd2, 8'h0}, "R12");
        step(1, 4'd3, 0, {32'd10, 8'h0}, {32'd3, 8'h0}, "R12");
        // R11: idle and reserved codes keep flags
        step(0, 4'd0, 0, {32'd0, 8'h0}, '0, "R11");
        step(1, 4'd13, 0, {32'd0, 8'h0}, '0, "R11");
        step(1, 4'd15, 1, {32'h8000_0000, 8'h0}, '0, "R11");
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 4'($urandom), 1'($urandom), rnd_word(), rnd_word(), "R3");
        step(0, 4'd0, 0, '0, '0, "R11");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule